// File: doc/BRIEF.md
# Decimating Filter Control Port and Start Sequencer

This block is the parameter write port and start controller of a two-stage decimating filter: a coarse integrator-comb stage followed by a symmetric FIR stage. A host drives a 16-bit data bus, a 2-bit register address, an active-low chip select and a write strobe. A write takes effect on the rising edge of the strobe. The block keeps the filter parameter fields, the FIR disable flag and the bypass flags. It also turns pairs of host writes into 20-bit coefficient writes, each with a running coefficient address.

The block also decides when the filter starts. Two active-low start inputs feed it. The asynchronous one passes through two synchronizing flops, and a one-cycle chain pulse is sent out on `chain_start_n`, so a second device can start on the same clock edge. The synchronous one is used as it is. A start is taken only after the combined start level has been high for at least two clock edges and then goes low. After a start the block stays running until reset, and it clears the FIR disable flag. While the block is not running, the sample accept output stays low.

Top module: `ddf_ctrl`

## Requirements
- R1: A register write happens only at a clock edge where `bus_wr` is high, `bus_wr` was low at the previous edge and `bus_cs_n` is low. Holding the strobe high for several cycles writes once. A strobe edge while `bus_cs_n` is high changes nothing.
- R2: Address 0 holds the FIR settings: bits [8:0] tap count, [12:9] FIR decimation, [13] even symmetry, [14] FIR bypass and [15] zero pre-adder. Address 2 holds the CIC settings: bits [9:0] CIC rate, [10] CIC bypass, [11] clear accumulator and [12] FIR disable. Address 3 holds the CIC shape: bits [2:0] stage count and [8:3] growth shift.
- R3: After reset every field reads zero except the FIR disable flag, which reads 1. Run, accept, FIR enable and the coefficient write pulse read 0, and `chain_start_n` reads 1.
- R4: Writes to address 1 alternate between two kinds. The first write of a pair stores the upper 16 coefficient bits. The second write supplies the low 4 bits in `bus_data[3:0]`. One clock after the second write, `coef_we` is high for exactly one cycle. At that point `coef_data` holds {first word, low nibble} and `coef_addr` holds the pointer value.
- R5: The coefficient pointer starts at 0 and advances by one after each completed coefficient. An address-2 write with bit 12 set returns the pointer to 0 and drops any half-written coefficient.
- R6: The asynchronous start input is sampled by two flops. When the synchronized level falls, `chain_start_n` goes low for exactly one cycle.
- R7: The combined start level is the synchronous start input ANDed with the synchronized asynchronous start. A start happens at an edge where this level is low and was high at each of the two previous edges. A level that is high for only one edge starts nothing.
- R8: `run` rises on a start and only reset clears it. `accept` equals `run`, so samples are refused before the first start.
- R9: A start clears the FIR disable flag, even when an address-2 write lands on the same edge. `fir_en` is `run` AND NOT disable, so clearing the flag with a write also re-enables the FIR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_data | input | 16 | Host write data |
| bus_addr | input | 2 | Host register address |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr | input | 1 | Write strobe, acts on its rising edge |
| async_start_n | input | 1 | Asynchronous start, active low |
| sync_start_n | input | 1 | Synchronous start, active low |
| chain_start_n | output | 1 | One-cycle start pulse for a chained device |
| fir_taps | output | 9 | FIR tap count field |
| fir_drate | output | 4 | FIR decimation field |
| fir_even_sym | output | 1 | Even symmetry select |
| fir_bypass | output | 1 | FIR bypass flag |
| fir_zero_pre | output | 1 | Zero pre-adder mode |
| cic_rate | output | 10 | CIC decimation field |
| cic_bypass | output | 1 | CIC bypass flag |
| fir_clear_acc | output | 1 | Clear accumulator mode |
| fir_disable | output | 1 | FIR disable flag |
| cic_stages | output | 3 | CIC stage count |
| cic_growth | output | 6 | CIC growth shift |
| coef_we | output | 1 | Coefficient write pulse |
| coef_addr | output | COEF_AW | Coefficient address |
| coef_data | output | 20 | Assembled coefficient |
| run | output | 1 | Sticky run state |
| accept | output | 1 | Input samples accepted |
| fir_en | output | 1 | FIR stage enabled |

## Verification
The bench sends the start level high for a single edge. A design that accepts a plain falling edge would start too early, and the run flag would mismatch from that cycle on. It holds the write strobe high for several cycles and also pulses it with chip select high. A level-sensitive port would write again, and a port that ignores chip select would load garbage into the fields. It also sets the disable flag in the middle of a coefficient stream, and it lets a start coincide with disable being set. A design that lost the pointer reset would write to the wrong addresses, and a design that gave the write priority over the start would leave the FIR disabled while running.

// File: rtl/ddf_ctrl.sv
module ddf_ctrl #(
  parameter int COEF_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        bus_data,
  input  logic [1:0]         bus_addr,
  input  logic               bus_cs_n,
  input  logic               bus_wr,
  input  logic               async_start_n,
  input  logic               sync_start_n,
  output logic               chain_start_n,
  output logic [8:0]         fir_taps,
  output logic [3:0]         fir_drate,
  output logic               fir_even_sym,
  output logic               fir_bypass,
  output logic               fir_zero_pre,
  output logic [9:0]         cic_rate,
  output logic               cic_bypass,
  output logic               fir_clear_acc,
  output logic               fir_disable,
  output logic [2:0]         cic_stages,
  output logic [5:0]         cic_growth,
  output logic               coef_we,
  output logic [COEF_AW-1:0] coef_addr,
  output logic [19:0]        coef_data,
  output logic               run,
  output logic               accept,
  output logic               fir_en
);

  logic        wr_q;
  logic [15:0] fir_q;
  logic [12:0] cic_q;
  logic [8:0]  shp_q;
  logic [15:0] hi_q;
  logic        half_q;
  logic [COEF_AW-1:0] ptr_q;
  logic        as1, as2, as3, h1, h2, run_q;

  wire wr_fire  = bus_wr & ~wr_q & ~bus_cs_n;
  wire dis_set  = wr_fire & (bus_addr == 2'd2) & bus_data[12];
  wire lvl      = sync_start_n & as2;
  wire start_ev = ~lvl & h1 & h2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_q <= 1'b0;
      fir_q <= '0;
      cic_q <= 13'h1000;
      shp_q <= '0;
    end else begin
      wr_q <= bus_wr;
      if (wr_fire && bus_addr == 2'd0) fir_q <= bus_data;
      if (wr_fire && bus_addr == 2'd2) cic_q <= bus_data[12:0];
      if (wr_fire && bus_addr == 2'd3) shp_q <= bus_data[8:0];
      if (start_ev) cic_q[12] <= 1'b0;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hi_q <= '0;
      half_q <= 1'b0;
      ptr_q <= '0;
      coef_we <= 1'b0;
      coef_addr <= '0;
      coef_data <= '0;
    end else begin
      coef_we <= 1'b0;
      if (dis_set) begin
        ptr_q <= '0;
        half_q <= 1'b0;
      end else if (wr_fire && bus_addr == 2'd1) begin
        if (!half_q) begin
          hi_q <= bus_data;
          half_q <= 1'b1;
        end else begin
          half_q <= 1'b0;
          coef_we <= 1'b1;
          coef_data <= {hi_q, bus_data[3:0]};
          coef_addr <= ptr_q;
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      as1 <= 1'b1;
      as2 <= 1'b1;
      as3 <= 1'b1;
      h1 <= 1'b0;
      h2 <= 1'b0;
      run_q <= 1'b0;
    end else begin
      as1 <= async_start_n;
      as2 <= as1;
      as3 <= as2;
      h1 <= lvl;
      h2 <= h1;
      if (start_ev) run_q <= 1'b1;
    end
  end

  assign chain_start_n = ~(as3 & ~as2);
  assign {fir_zero_pre, fir_bypass, fir_even_sym, fir_drate, fir_taps} = fir_q;
  assign {fir_disable, fir_clear_acc, cic_bypass, cic_rate} = cic_q;
  assign {cic_growth, cic_stages} = shp_q;
  assign run = run_q;
  assign accept = run_q;
  assign fir_en = run_q & ~cic_q[12];

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst) run |=> run); // R8
  AST_START_ENABLES: assert property (@(posedge clk) disable iff (rst) $rose(run) |-> !fir_disable); // R9
  AST_CHAIN_PULSE: assert property (@(posedge clk) disable iff (rst) !chain_start_n |=> chain_start_n); // R6
  AST_COEF_SINGLE: assert property (@(posedge clk) disable iff (rst) coef_we |=> !coef_we); // R4
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst) !$past(bus_wr) |-> $stable(fir_taps)); // R1

endmodule

// File: tb/ddf_ctrl_test.sv
`timescale 1ns/1ps
module ddf_ctrl_test;
  logic clk = 0, rst = 1;
  logic [15:0] bus_data = 0;
  logic [1:0] bus_addr = 0;
  logic bus_cs_n = 1, bus_wr = 0, async_start_n = 1, sync_start_n = 0;
  logic chain_start_n, fir_even_sym, fir_bypass, fir_zero_pre, cic_bypass;
  logic fir_clear_acc, fir_disable, coef_we, run, accept, fir_en;
  logic [8:0] fir_taps; logic [3:0] fir_drate; logic [9:0] cic_rate;
  logic [2:0] cic_stages; logic [5:0] cic_growth;
  logic [7:0] coef_addr; logic [19:0] coef_data;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddf_ctrl uut (.*);

  // Behavioural reference
  int m_fir, m_cic, m_shp, m_hi, m_half, m_ptr, m_we, m_cd, m_ca, m_run, m_wrp;
  int aq[$], cq[$];
  int f, c, e;
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_fir = 0; m_cic = 'h1000; m_shp = 0; m_hi = 0; m_half = 0; m_ptr = 0;
      m_we = 0; m_cd = 0; m_ca = 0; m_run = 0; m_wrp = 0;
      aq = {1, 1, 1}; cq = {0, 0};
    end else begin
      f = (bus_wr && !m_wrp && !bus_cs_n) ? 1 : 0;
      c = (sync_start_n && aq[1]) ? 1 : 0;
      e = (!c && cq[0] && cq[1]) ? 1 : 0;
      m_wrp = bus_wr;
      m_we = 0;
      if (f && bus_addr == 0) m_fir = bus_data;
      if (f && bus_addr == 3) m_shp = bus_data & 'h1ff;
      if (f && bus_addr == 2) begin
        m_cic = bus_data & 'h1fff;
        if (bus_data[12]) begin m_ptr = 0; m_half = 0; end
      end
      if (f && bus_addr == 1) begin
        if (m_half == 0) begin m_hi = bus_data; m_half = 1; end
        else begin
          m_half = 0; m_we = 1; m_cd = (m_hi << 4) | (bus_data & 'hf);
          m_ca = m_ptr; m_ptr = (m_ptr + 1) % 256;
        end
      end
      if (e) begin m_run = 1; m_cic = m_cic & 'h0fff; end
      aq.push_front(async_start_n ? 1 : 0); void'(aq.pop_back());
      cq.push_front(c); void'(cq.pop_back());
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R2 fir fields", {fir_zero_pre, fir_bypass, fir_even_sym, fir_drate, fir_taps}, m_fir);
    chk("R2 cic fields", {fir_clear_acc, cic_bypass, cic_rate}, m_cic & 'hfff);
    chk("R2 shape fields", {cic_growth, cic_stages}, m_shp);
    chk("R9 disable", fir_disable, (m_cic >> 12) & 1);
    chk("R9 fir_en", fir_en, m_run && !((m_cic >> 12) & 1));
    chk("R4 coef_we", coef_we, m_we);
    if (m_we) chk("R4 coef data/addr", {coef_addr, coef_data}, (m_ca << 20) | m_cd);
    chk("R6 chain", chain_start_n, !(aq[2] && !aq[1]));
    chk("R8 run/accept", {run, accept}, {m_run[0], m_run[0]});
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic cs_n = 0, input int hold = 1);
    @(negedge clk); bus_addr = a; bus_data = d; bus_cs_n = cs_n; bus_wr = 1;
    repeat (hold) @(negedge clk);
    bus_wr = 0;
    @(negedge clk); bus_cs_n = 1;
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #0.1;
    // R3 reset state
    chk("R3 disable set", fir_disable, 1);
    chk("R3 fields clear", {fir_taps, fir_drate, cic_rate, cic_stages, cic_growth, fir_bypass, cic_bypass}, 0);
    chk("R3 idle outputs", {run, accept, fir_en, coef_we, chain_start_n}, 5'b00001);
    wr(2'd0, 16'hBEEF, 1);            // R1 ignored, chip select high
    chk("R1 no write", fir_taps, 0);
    wr(2'd0, 16'h5A3C, 0, 4);          // R1 strobe held: one write
    wr(2'd2, 16'h1ABC);
    wr(2'd3, 16'h0155);
    wr(2'd1, 16'h1234); wr(2'd1, 16'h0005);  // R4
    wr(2'd1, 16'hFFFF); wr(2'd1, 16'h000A);
    wr(2'd1, 16'h0F0F);                       // half coefficient
    wr(2'd2, 16'h1000);                       // R5 pointer reset
    wr(2'd1, 16'hCAFE); wr(2'd1, 16'h0003);
    chk("R8 accept low before start", accept, 0);
    // R7 one-edge high level: no start
    sync_start_n = 1; idle(1); sync_start_n = 0; idle(3);
    chk("R7 no start", run, 0);
    sync_start_n = 1; idle(4);
    // R6 async start
    async_start_n = 0; idle(4); async_start_n = 1; idle(4);
    chk("R8 started", run, 1);
    chk("R9 disable cleared", fir_disable, 0);
    wr(2'd2, 16'h1000);                       // set disable
    chk("R9 fir_en off", fir_en, 0);
    wr(2'd1, 16'h0001); wr(2'd1, 16'h0002);
    wr(2'd2, 16'h0000);                       // clear by write
    chk("R9 re-enabled", fir_en, 1);
    wr(2'd2, 16'h1000);
    // sync start with a write landing together
    sync_start_n = 0; bus_addr = 2; bus_data = 16'h1000; bus_cs_n = 0; bus_wr = 1;
    idle(1); bus_wr = 0; idle(1); bus_cs_n = 1; sync_start_n = 1; idle(4);
    chk("R9 start beats write", fir_disable, 0);
    idle(5);
    chk("R8 still running", run, 1);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    #0.1;
    chk("R8 reset stops", run, 0);
    idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule